// File: doc/BRIEF.md
# Reset Status and Power-Mode Register

This block is a single-address status and control word on the CPU side of a small microcontroller. It records why the device last left reset: either a watchdog timeout or a power-on/external reset. It drives two low-power states. Sleep ends as soon as any interrupt becomes pending. Halt ends only through a hardware reset. The word also shows a read-only copy of the CPU's global interrupt enable flag.

The watchdog-enable output is derived from the power-on flag. Clearing that flag with a software write of 0 arms the watchdog. Software can clear the two cause flags but can never set them. A write is a one-cycle strobe. A read returns the live word combinationally, and the unused bit positions always read as zero.

Top module: `sysctl_status_reg`

## Requirements
- R1: After the asynchronous power-on reset (`rst_n` low), the read word is 0x10 when `gie_flag` is 0. In that state `sleep_o`, `halt_o` and `wdt_enable_o` are all 0.
- R2: The read word is combinational and has this layout:
  - bit 7 is the global interrupt flag copy;
  - bit 5 is the watchdog-cause flag;
  - bit 4 is the power-on flag;
  - bit 3 is sleep;
  - bit 0 is stop;
  - bits 6, 2 and 1 always read 0.
- R3: A write with bit 5 (or bit 4) at 0 clears the watchdog-cause flag (or the power-on flag) at the strobed clock edge. A write with that bit at 1 leaves the flag unchanged, so software can never set it.
- R4: A pulse on `wdt_rst_i` sampled at a clock edge has these effects at that edge:
  - it sets the watchdog-cause flag;
  - it clears sleep and stop;
  - it leaves the power-on flag unchanged.
  It takes priority over a write strobed in the same cycle.
- R5: `wdt_enable_o` is 1 exactly when the power-on flag (bit 4) is 0.
- R6: A write with bit 3 at 1 raises `sleep_o` one clock after the strobe. A write with bit 3 at 0 clears it.
- R7: While `irq_pending` is high at a clock edge, sleep is cleared at that edge. This wins over a same-cycle write of 1. A wake therefore drops `sleep_o` one clock after the interrupt is seen.
- R8: A write with bit 0 at 1 raises `halt_o` one clock after the strobe. A write with bit 0 at 0 has no effect. Only `wdt_rst_i` or `rst_n` clears stop.
- R9: Writes to bit 7 and to the reserved bits 6, 2 and 1 change nothing. Bit 7 always follows `gie_flag`.
- R10: Asserting `rst_n` from any state restores the R1 values. In particular it clears the watchdog-cause flag and sets the power-on flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on/external reset, asynchronous, active low |
| wdt_rst_i | input | 1 | Watchdog reset event, synchronous one-cycle pulse |
| wr_en | input | 1 | One-cycle write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read word |
| irq_pending | input | 1 | Any interrupt pending |
| gie_flag | input | 1 | CPU global interrupt enable flag |
| sleep_o | output | 1 | Sleep state request |
| halt_o | output | 1 | CPU halt |
| wdt_enable_o | output | 1 | Watchdog enable |

## Verification
The bench builds the block with its default parameters: an 8-bit word, with the bit positions that the neighbouring CPU logic decodes. With these values every reachable state can be hit, including these collisions:
- a watchdog event arriving together with a write;
- an interrupt arriving in the same cycle as a write of 1 to sleep;
- a power-on reset landing while halted.

The tests also try writes of 0 to stop and writes of 1 to the cause flags, and confirm at the read port that neither has any effect.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned WORD_W  = 8;
  localparam int unsigned POS_GIE = 7;
  localparam int unsigned POS_WDR = 5;
  localparam int unsigned POS_POR = 4;
  localparam int unsigned POS_SLP = 3;
  localparam int unsigned POS_STP = 0;

  typedef struct packed {
    logic wdr;
    logic por;
    logic slp;
    logic stp;
  } ctl_state_t;

  localparam ctl_state_t STATE_RESET = '{wdr: 1'b0, por: 1'b1, slp: 1'b0, stp: 1'b0};

  // software may only clear: result is current AND written bit
  function automatic logic clear_only(input logic cur, input logic wbit);
    return cur & wbit;
  endfunction

  // stop can only be raised by software
  function automatic logic set_only(input logic cur, input logic wbit);
    return cur | wbit;
  endfunction

  // sleep next value: wake dominates, then write, then hold
  function automatic logic sleep_next(input logic cur, input logic wr,
                                      input logic wbit, input logic irq);
    logic n;
    n = wr ? wbit : cur;
    return irq ? 1'b0 : n;
  endfunction
endpackage

// File: rtl/sysctl_reset_flags.sv
module sysctl_reset_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic wdt_rst_i,
  input  logic wr_en,
  input  logic wr_wdr,
  input  logic wr_por,
  output logic wdr_q,
  output logic por_q
);
  import sysctl_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdr_q <= STATE_RESET.wdr;
      por_q <= STATE_RESET.por;
    end else if (wdt_rst_i) begin
      wdr_q <= 1'b1;
      por_q <= por_q;
    end else if (wr_en) begin
      wdr_q <= clear_only(wdr_q, wr_wdr);
      por_q <= clear_only(por_q, wr_por);
    end
  end
endmodule

// File: rtl/sysctl_power_mode.sv
module sysctl_power_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic wdt_rst_i,
  input  logic wr_en,
  input  logic wr_slp,
  input  logic wr_stp,
  input  logic irq_pending,
  output logic slp_q,
  output logic stp_q,
  output logic wake_evt
);
  import sysctl_pkg::*;

  assign wake_evt = slp_q & irq_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slp_q <= STATE_RESET.slp;
      stp_q <= STATE_RESET.stp;
    end else if (wdt_rst_i) begin
      slp_q <= 1'b0;
      stp_q <= 1'b0;
    end else begin
      slp_q <= sleep_next(slp_q, wr_en, wr_slp, irq_pending);
      if (wr_en) stp_q <= set_only(stp_q, wr_stp);
    end
  end
endmodule

// File: rtl/sysctl_readback.sv
module sysctl_readback #(
  parameter int unsigned WORD_W = sysctl_pkg::WORD_W
) (
  input  logic              gie,
  input  sysctl_pkg::ctl_state_t st,
  output logic [WORD_W-1:0] word
);
  import sysctl_pkg::*;

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    if (i == POS_GIE)      begin : g_gie assign word[i] = gie;    end
    else if (i == POS_WDR) begin : g_wdr assign word[i] = st.wdr; end
    else if (i == POS_POR) begin : g_por assign word[i] = st.por; end
    else if (i == POS_SLP) begin : g_slp assign word[i] = st.slp; end
    else if (i == POS_STP) begin : g_stp assign word[i] = st.stp; end
    else                   begin : g_rsv assign word[i] = 1'b0;   end
  end
endmodule

// File: rtl/sysctl_status_reg.sv
module sysctl_status_reg #(
  parameter int unsigned WORD_W = sysctl_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wdt_rst_i,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic              irq_pending,
  input  logic              gie_flag,
  output logic              sleep_o,
  output logic              halt_o,
  output logic              wdt_enable_o
);
  import sysctl_pkg::*;

  ctl_state_t st;
  logic       wake_evt;
  logic       unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[POS_GIE], wr_data[6], wr_data[2], wr_data[1]};

  sysctl_reset_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .wdt_rst_i (wdt_rst_i),
    .wr_en     (wr_en),
    .wr_wdr    (wr_data[POS_WDR]),
    .wr_por    (wr_data[POS_POR]),
    .wdr_q     (st.wdr),
    .por_q     (st.por)
  );

  sysctl_power_mode u_pm (
    .clk         (clk),
    .rst_n       (rst_n),
    .wdt_rst_i   (wdt_rst_i),
    .wr_en       (wr_en),
    .wr_slp      (wr_data[POS_SLP]),
    .wr_stp      (wr_data[POS_STP]),
    .irq_pending (irq_pending),
    .slp_q       (st.slp),
    .stp_q       (st.stp),
    .wake_evt    (wake_evt)
  );

  sysctl_readback #(.WORD_W(WORD_W)) u_rb (
    .gie  (gie_flag),
    .st   (st),
    .word (rd_data)
  );

  assign sleep_o      = st.slp;
  assign halt_o       = st.stp;
  assign wdt_enable_o = ~st.por;
endmodule

// File: rtl/sysctl_status_reg_chk.sv
module sysctl_status_reg_chk #(
  parameter int unsigned WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wdt_rst_i,
  input logic              irq_pending,
  input logic              gie_flag,
  input logic [WORD_W-1:0] rd_data,
  input logic              sleep_o,
  input logic              halt_o,
  input logic              wdt_enable_o,
  input logic              wake_evt
);
  p_no_sw_set_wdr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_rst_i |=> !$rose(rd_data[5]));
  p_no_sw_set_por_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> !$rose(rd_data[4]));
  p_wdt_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_i |=> (rd_data[5] && !sleep_o && !halt_o && $stable(rd_data[4])));
  p_wdt_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_enable_o != rd_data[4]);
  p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt || irq_pending) |=> !sleep_o);
  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o && !wdt_rst_i) |=> halt_o);
  p_gie_mirror_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] == gie_flag);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[6] == 1'b0) && (rd_data[2] == 1'b0) && (rd_data[1] == 1'b0));
endmodule

bind sysctl_status_reg sysctl_status_reg_chk #(.WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wdt_rst_i    (wdt_rst_i),
  .irq_pending  (irq_pending),
  .gie_flag     (gie_flag),
  .rd_data      (rd_data),
  .sleep_o      (sleep_o),
  .halt_o       (halt_o),
  .wdt_enable_o (wdt_enable_o),
  .wake_evt     (wake_evt)
);

// File: tb/tb_sysctl_status_reg.sv
`timescale 1ns/1ps
module tb_sysctl_status_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wdt_rst_i = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq_pending = 1'b0;
  logic       gie_flag = 1'b0;
  logic       sleep_o, halt_o, wdt_enable_o;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sysctl_status_reg dut (
    .clk(clk), .rst_n(rst_n), .wdt_rst_i(wdt_rst_i), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq_pending(irq_pending),
    .gie_flag(gie_flag), .sleep_o(sleep_o), .halt_o(halt_o),
    .wdt_enable_o(wdt_enable_o)
  );

  // expected word from bench model fields
  function automatic logic [7:0] exp_word(input logic g, input logic w,
                                          input logic p, input logic s, input logic t);
    return {g, 1'b0, w, p, s, 2'b00, t};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic t_reset_values();
    do_reset();
    chk("R1 word", rd_data, 8'h10);
    chk("R1 outs", {5'b0, sleep_o, halt_o, wdt_enable_o}, 8'h00);
    gie_flag = 1'b1; #1;
    chk("R2 gie comb", rd_data, exp_word(1, 0, 1, 0, 0));
    gie_flag = 1'b0; #1;
  endtask

  task automatic t_flag_clear();
    do_reset();
    wr(8'hFF & ~8'h08 & ~8'h01);
    chk("R3 write1 keeps por", rd_data, exp_word(0, 0, 1, 0, 0));
    wr(8'h00);
    chk("R3 clear por", rd_data, exp_word(0, 0, 0, 0, 0));
    chk("R5 wdt enabled", {7'b0, wdt_enable_o}, 8'h01);
    wr(8'h30);
    chk("R3 no sw set", rd_data, exp_word(0, 0, 0, 0, 0));
  endtask

  task automatic t_sleep();
    do_reset();
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h18;
    #1; chk("R6 before edge", {7'b0, sleep_o}, 8'h00);
    @(negedge clk); wr_en = 1'b0;
    chk("R6 sleep set", {7'b0, sleep_o}, 8'h01);
    wr(8'h10);
    chk("R6 sleep cleared", {7'b0, sleep_o}, 8'h00);
  endtask

  task automatic t_wake();
    do_reset();
    wr(8'h18);
    @(negedge clk); irq_pending = 1'b1;
    #1; chk("R7 still asleep", {7'b0, sleep_o}, 8'h01);
    @(negedge clk); irq_pending = 1'b0;
    chk("R7 woke", {7'b0, sleep_o}, 8'h00);
    @(negedge clk); irq_pending = 1'b1; wr_en = 1'b1; wr_data = 8'h18;
    @(negedge clk); irq_pending = 1'b0; wr_en = 1'b0;
    chk("R7 irq beats write", {7'b0, sleep_o}, 8'h00);
  endtask

  task automatic t_stop();
    do_reset();
    wr(8'h11);
    chk("R8 halt set", {7'b0, halt_o}, 8'h01);
    wr(8'h10);
    chk("R8 write0 no effect", rd_data, exp_word(0, 0, 1, 0, 1));
    do_reset();
    chk("R10 por clears halt", {7'b0, halt_o}, 8'h00);
  endtask

  task automatic t_wdt_event();
    do_reset();
    wr(8'h00);
    wr(8'h09);
    @(negedge clk); wdt_rst_i = 1'b1; wr_en = 1'b1; wr_data = 8'h19;
    @(negedge clk); wdt_rst_i = 1'b0; wr_en = 1'b0;
    chk("R4 wdt event", rd_data, exp_word(0, 1, 0, 0, 0));
    chk("R5 still enabled", {7'b0, wdt_enable_o}, 8'h01);
    wr(8'h20);
    chk("R3 wdr kept by 1", rd_data, exp_word(0, 1, 0, 0, 0));
    wr(8'h00);
    chk("R3 wdr cleared", rd_data, exp_word(0, 0, 0, 0, 0));
    @(negedge clk); wdt_rst_i = 1'b1;
    @(negedge clk); wdt_rst_i = 1'b0;
    do_reset();
    chk("R10 por clears wdr", rd_data, 8'h10);
  endtask

  task automatic t_ignored();
    do_reset();
    wr(8'hD6);
    chk("R9 gie/reserved ignored", rd_data, exp_word(0, 0, 1, 0, 0));
    gie_flag = 1'b1; #1;
    chk("R9 gie follows input", rd_data, exp_word(1, 0, 1, 0, 0));
    gie_flag = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    t_reset_values();
    t_flag_clear();
    t_sleep();
    t_wake();
    t_stop();
    t_wdt_event();
    t_ignored();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule